// File: doc/BRIEF.md
# Warp Issue Sequencer

This block sequences groups of 32 threads ("warps") onto a row of 8 scalar lanes. Every thread of a warp runs the same instruction, so the instruction is split into 4 consecutive beats, each carrying the PC, the warp number, the beat index and an 8-bit lane-enable mask taken from the warp's 32-bit thread mask. Threads that took a different branch are simply switched off in that mask. The lane datapath, register files and memory sit outside the block.

Up to 24 warp contexts stay resident, each with its own PC and thread mask, written through a load port. A per-warp ready vector, driven by the surrounding pipeline (for example cleared while a warp waits for memory), tells the sequencer which warps may issue. At every instruction boundary the sequencer picks the next eligible warp round-robin, starting after the last warp it issued, so long-latency waits of one warp are covered by the others. When no warp can go, a bubble is issued. A load and a PC step for the same warp in the same cycle resolve in favour of the load.

Top module: `wis_warp_sequencer`

## Requirements
- R1: After reset no beat is issued (iss_valid_o low, iss_lanes_o zero), every PC is 0 and every thread mask is zero, so no warp is eligible until it has been loaded.
- R2: A load (ld_valid_i high at a clock edge) writes ld_pc_i and ld_mask_i into the context of warp ld_warp_i; the warp can be picked at any boundary edge after the load edge.
- R3: One instruction occupies exactly 4 consecutive issue cycles with iss_beat_o counting 0,1,2,3 and the same warp and PC on all four; the warp never changes mid-instruction, even if its ready bit falls.
- R4: On beat k (k = 0..3) iss_lanes_o equals bits [8k+7:8k] of the issuing warp's thread mask.
- R5: A warp's PC increases by 1 after its beat 3 is issued and does not change while the warp is not issuing.
- R6: At a boundary the chosen warp is the first eligible one in the order last+1, last+2, ... wrapping from 23 to 0, where last is the warp issued most recently (23 after reset, so warp 0 ranks first).
- R7: A warp is eligible only when its warp_ready_i bit is 1 and its thread mask is non-zero; with no eligible warp a bubble is issued (iss_valid_o low, iss_lanes_o zero) and issue resumes on the cycle after a warp becomes eligible.
- R8: When an eligible warp exists, its beat 0 follows the previous beat 3 in the very next cycle; ready bits are sampled only at boundary edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ld_valid_i | input | 1 | Write a warp context this cycle |
| ld_warp_i | input | 5 | Warp number to write |
| ld_pc_i | input | 16 | PC to write |
| ld_mask_i | input | 32 | Thread mask to write, bit t enables thread t |
| warp_ready_i | input | 24 | Per-warp ready bits |
| iss_valid_o | output | 1 | A beat is issued this cycle |
| iss_warp_o | output | 5 | Warp number of the issued beat |
| iss_beat_o | output | 2 | Beat index 0..3 within the instruction |
| iss_lanes_o | output | 8 | Lane enables for this beat |
| iss_pc_o | output | 16 | PC of the issued instruction |

## Verification
The bench drops a warp's ready bit in the middle of its instruction; a sequencer that switched warps early would show a new warp number on beats 1 to 3. It puts eligible warps at 0, 5 and 23 to catch a pointer that fails to wrap or restarts at 0 instead of after the last issuer, and it runs a lone warp to confirm back-to-back issue with the PC stepping exactly once. A warp with ready set but a zero mask must never issue, and a bubble followed by re-arming must resume with the PC advanced only once, catching a PC that counts during idle cycles.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int WIS_NUM_WARPS    = 24;
  localparam int WIS_LANES        = 8;
  localparam int WIS_WARP_THREADS = 32;
  localparam int WIS_PC_W         = 16;
endpackage

// File: rtl/wis_ctx_file.sv
// Per-warp PC and thread mask storage with a load port, a PC step port
// and a read port for the warp/beat currently issuing.
module wis_ctx_file #(
  parameter int N       = 24,
  parameter int THREADS = 32,
  parameter int LANES   = 8,
  parameter int PC_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_valid_i,
  input  logic [$clog2(N)-1:0]          ld_warp_i,
  input  logic [PC_W-1:0]               ld_pc_i,
  input  logic [THREADS-1:0]            ld_mask_i,
  input  logic                          adv_i,
  input  logic [$clog2(N)-1:0]          adv_warp_i,
  input  logic [$clog2(N)-1:0]          rd_warp_i,
  input  logic [$clog2(THREADS/LANES)-1:0] rd_beat_i,
  output logic [PC_W-1:0]               rd_pc_o,
  output logic [LANES-1:0]              rd_lanes_o,
  output logic [N-1:0]                  mask_nz_o
);
  localparam int WID_W = $clog2(N);

  logic [PC_W-1:0]    pc_arr   [N];
  logic [THREADS-1:0] mask_arr [N];

  for (genvar w = 0; w < N; w++) begin : g_ctx
    logic               ld_hit;
    logic               inc_hit;
    logic               en;
    logic [PC_W-1:0]    pc_d;
    logic [PC_W-1:0]    pc_r;
    logic [THREADS-1:0] mask_d;
    logic [THREADS-1:0] mask_r;

    always_comb begin
      ld_hit  = ld_valid_i && (ld_warp_i == WID_W'(w));
      inc_hit = adv_i && (adv_warp_i == WID_W'(w));
      en      = ld_hit || inc_hit;
      pc_d    = ld_hit ? ld_pc_i : (pc_r + PC_W'(1));
      mask_d  = ld_hit ? ld_mask_i : mask_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_r   <= '0;
        mask_r <= '0;
      end else if (en) begin
        pc_r   <= pc_d;
        mask_r <= mask_d;
      end
    end

    assign pc_arr[w]    = pc_r;
    assign mask_arr[w]  = mask_r;
    assign mask_nz_o[w] = |mask_r;
  end

  logic [THREADS-1:0] rd_mask;

  always_comb begin
    rd_pc_o    = pc_arr[rd_warp_i];
    rd_mask    = mask_arr[rd_warp_i];
    rd_lanes_o = rd_mask[rd_beat_i*LANES +: LANES];
  end
endmodule

// File: rtl/wis_rr_pick.sv
// Round-robin selection: first eligible warp after last_i, wrapping.
module wis_rr_pick #(
  parameter int N = 24
) (
  input  logic [N-1:0]         elig_i,
  input  logic [$clog2(N)-1:0] last_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] grant_o
);
  localparam int WID_W = $clog2(N);

  logic [WID_W:0] idx;

  always_comb begin
    any_o   = 1'b0;
    grant_o = '0;
    idx     = '0;
    for (int i = 1; i <= N; i++) begin
      idx = {1'b0, last_i} + (WID_W+1)'(i);
      if (idx >= (WID_W+1)'(N)) idx = idx - (WID_W+1)'(N);
      if (!any_o && elig_i[idx[WID_W-1:0]]) begin
        any_o   = 1'b1;
        grant_o = idx[WID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wis_beat_ctrl.sv
// Issue state: active flag, current warp, beat counter, last issuer.
module wis_beat_ctrl #(
  parameter int N     = 24,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pick_any_i,
  input  logic [$clog2(N)-1:0]     pick_warp_i,
  output logic                     active_o,
  output logic [$clog2(N)-1:0]     cur_warp_o,
  output logic [$clog2(BEATS)-1:0] beat_o,
  output logic [$clog2(N)-1:0]     last_warp_o,
  output logic                     adv_o
);
  localparam int WID_W  = $clog2(N);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS-1);

  logic              active_q, active_d;
  logic [WID_W-1:0]  cur_q, cur_d;
  logic [WID_W-1:0]  last_q, last_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              boundary;

  always_comb begin
    boundary = !active_q || (beat_q == LAST_BEAT);
    adv_o    = active_q && (beat_q == LAST_BEAT);
    active_d = active_q;
    cur_d    = cur_q;
    last_d   = last_q;
    beat_d   = beat_q;
    if (boundary) begin
      active_d = pick_any_i;
      beat_d   = '0;
      if (pick_any_i) begin
        cur_d  = pick_warp_i;
        last_d = pick_warp_i;
      end
    end else begin
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      last_q   <= WID_W'(N-1);
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      cur_q    <= cur_d;
      last_q   <= last_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o    = active_q;
  assign cur_warp_o  = cur_q;
  assign beat_o      = beat_q;
  assign last_warp_o = last_q;
endmodule

// File: rtl/wis_warp_sequencer.sv
module wis_warp_sequencer #(
  parameter int NUM_WARPS    = wis_pkg::WIS_NUM_WARPS,
  parameter int LANES        = wis_pkg::WIS_LANES,
  parameter int WARP_THREADS = wis_pkg::WIS_WARP_THREADS,
  parameter int PC_W         = wis_pkg::WIS_PC_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ld_valid_i,
  input  logic [$clog2(NUM_WARPS)-1:0]         ld_warp_i,
  input  logic [PC_W-1:0]                      ld_pc_i,
  input  logic [WARP_THREADS-1:0]              ld_mask_i,
  input  logic [NUM_WARPS-1:0]                 warp_ready_i,
  output logic                                 iss_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0]         iss_warp_o,
  output logic [$clog2(WARP_THREADS/LANES)-1:0] iss_beat_o,
  output logic [LANES-1:0]                     iss_lanes_o,
  output logic [PC_W-1:0]                      iss_pc_o
);
  localparam int BEATS  = WARP_THREADS / LANES;
  localparam int WID_W  = $clog2(NUM_WARPS);
  localparam int BEAT_W = $clog2(BEATS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic                 active;
  logic [WID_W-1:0]     cur_warp;
  logic [WID_W-1:0]     last_warp;
  logic [BEAT_W-1:0]    beat;
  logic                 adv;
  logic                 pick_any;
  logic [WID_W-1:0]     pick_warp;
  logic [NUM_WARPS-1:0] mask_nz;
  logic [NUM_WARPS-1:0] elig;
  logic [PC_W-1:0]      rd_pc;
  logic [LANES-1:0]     rd_lanes;

  assign elig = warp_ready_i & mask_nz;

  wis_ctx_file #(
    .N(NUM_WARPS), .THREADS(WARP_THREADS), .LANES(LANES), .PC_W(PC_W)
  ) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ld_valid_i (ld_valid_i),
    .ld_warp_i  (ld_warp_i),
    .ld_pc_i    (ld_pc_i),
    .ld_mask_i  (ld_mask_i),
    .adv_i      (adv),
    .adv_warp_i (cur_warp),
    .rd_warp_i  (cur_warp),
    .rd_beat_i  (beat),
    .rd_pc_o    (rd_pc),
    .rd_lanes_o (rd_lanes),
    .mask_nz_o  (mask_nz)
  );

  wis_rr_pick #(.N(NUM_WARPS)) u_pick (
    .elig_i  (elig),
    .last_i  (last_warp),
    .any_o   (pick_any),
    .grant_o (pick_warp)
  );

  wis_beat_ctrl #(.N(NUM_WARPS), .BEATS(BEATS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .pick_any_i  (pick_any),
    .pick_warp_i (pick_warp),
    .active_o    (active),
    .cur_warp_o  (cur_warp),
    .beat_o      (beat),
    .last_warp_o (last_warp),
    .adv_o       (adv)
  );

  always_comb begin
    iss_valid_o = active;
    iss_warp_o  = active ? cur_warp : '0;
    iss_beat_o  = active ? beat     : '0;
    iss_lanes_o = active ? rd_lanes : '0;
    iss_pc_o    = active ? rd_pc    : '0;
  end
endmodule

// File: rtl/wis_warp_sequencer_chk.sv
module wis_warp_sequencer_chk #(
  parameter int N      = 24,
  parameter int WID_W  = 5,
  parameter int BEAT_W = 2,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              ld_valid_i,
  input logic [WID_W-1:0]  ld_warp_i,
  input logic [N-1:0]      warp_ready_i,
  input logic              iss_valid_o,
  input logic [WID_W-1:0]  iss_warp_o,
  input logic [BEAT_W-1:0] iss_beat_o,
  input logic [LANES-1:0]  iss_lanes_o,
  input logic [15:0]       iss_pc_o
);
  localparam logic [BEAT_W-1:0] LAST = '1;

  logic [N-1:0] ready_seen_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) ready_seen_q <= '0;
    else            ready_seen_q <= warp_ready_i;
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid_o && iss_beat_o != LAST |=> iss_valid_o && iss_beat_o == $past(iss_beat_o) + BEAT_W'(1)); // R3
  AST_WARP_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid_o && iss_beat_o != LAST |=> iss_warp_o == $past(iss_warp_o)); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid_o && iss_beat_o != LAST && !(ld_valid_i && ld_warp_i == iss_warp_o)
    |=> iss_pc_o == $past(iss_pc_o)); // R3
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(iss_valid_o) |-> iss_beat_o == '0); // R3
  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid_o && iss_beat_o == '0 |-> ready_seen_q[iss_warp_o]); // R7
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !iss_valid_o |-> iss_lanes_o == '0); // R7
endmodule

bind wis_warp_sequencer wis_warp_sequencer_chk #(
  .N(NUM_WARPS), .WID_W(WID_W), .BEAT_W(BEAT_W), .LANES(LANES)
) u_chk (
  .clk          (clk),
  .rst_n_int    (rst_n_int),
  .ld_valid_i   (ld_valid_i),
  .ld_warp_i    (ld_warp_i),
  .warp_ready_i (warp_ready_i),
  .iss_valid_o  (iss_valid_o),
  .iss_warp_o   (iss_warp_o),
  .iss_beat_o   (iss_beat_o),
  .iss_lanes_o  (iss_lanes_o),
  .iss_pc_o     (iss_pc_o)
);

// File: tb/test_wis_warp_sequencer.sv
`timescale 1ns/1ps
module test_wis_warp_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid_i;
  logic [4:0]  ld_warp_i;
  logic [15:0] ld_pc_i;
  logic [31:0] ld_mask_i;
  logic [23:0] warp_ready_i;
  logic        iss_valid_o;
  logic [4:0]  iss_warp_o;
  logic [1:0]  iss_beat_o;
  logic [7:0]  iss_lanes_o;
  logic [15:0] iss_pc_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wis_warp_sequencer i_wis_warp_sequencer (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid_i), .ld_warp_i(ld_warp_i),
    .ld_pc_i(ld_pc_i), .ld_mask_i(ld_mask_i), .warp_ready_i(warp_ready_i),
    .iss_valid_o(iss_valid_o), .iss_warp_o(iss_warp_o), .iss_beat_o(iss_beat_o),
    .iss_lanes_o(iss_lanes_o), .iss_pc_o(iss_pc_o)
  );

  task automatic check_beat(input string req, input bit v, input int w, input int b,
                            input logic [7:0] lanes, input int pc);
    checks++;
    if (iss_valid_o !== v || (v && (iss_warp_o !== 5'(w) || iss_beat_o !== 2'(b) ||
        iss_pc_o !== 16'(pc))) || iss_lanes_o !== lanes) begin
      errors++;
      $display("FAIL %s: got v=%0b w=%0d b=%0d lanes=%02h pc=%0d, expected v=%0b w=%0d b=%0d lanes=%02h pc=%0d",
               req, iss_valid_o, iss_warp_o, iss_beat_o, iss_lanes_o, iss_pc_o,
               v, w, b, lanes, pc);
    end
  endtask

  // one full instruction, called at a negedge before the beat-0 edge
  task automatic expect_instr(input string req, input int w, input int pc, input logic [31:0] m);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      check_beat(req, 1'b1, w, b, m[8*b +: 8], pc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ld_valid_i = 1'b0; ld_warp_i = '0; ld_pc_i = '0; ld_mask_i = '0;
    warp_ready_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input int w, input int pc, input logic [31:0] m);
    ld_valid_i = 1'b1; ld_warp_i = 5'(w); ld_pc_i = 16'(pc); ld_mask_i = m;
    @(negedge clk);
    ld_valid_i = 1'b0;
  endtask

  // R1, R7: idle after reset, zero masks keep ready warps out
  task automatic t_reset_state();
    do_reset();
    check_beat("R1 reset idle", 1'b0, 0, 0, 8'h00, 0);
    warp_ready_i = '1;
    repeat (3) begin
      @(negedge clk);
      check_beat("R1 zero masks never issue", 1'b0, 0, 0, 8'h00, 0);
    end
  endtask

  // R2, R4, R5, R8: single warp, lane slices, PC step, back-to-back
  task automatic t_single_warp();
    logic [31:0] m = 32'hA5C3_0F81;
    do_reset();
    load(3, 10, m);
    warp_ready_i[3] = 1'b1;
    expect_instr("R4 lane slices", 3, 10, m);
    expect_instr("R5 pc step back-to-back R8", 3, 11, m);
    expect_instr("R2 load applied R5", 3, 12, m);
  endtask

  // R6: round-robin with wrap across 23 -> 0
  task automatic t_round_robin();
    do_reset();
    load(23, 300, '1);
    load(5, 200, '1);
    load(0, 100, '1);
    warp_ready_i[0] = 1'b1; warp_ready_i[5] = 1'b1; warp_ready_i[23] = 1'b1;
    expect_instr("R6 first after reset", 0, 100, '1);
    expect_instr("R6 next after 0", 5, 200, '1);
    expect_instr("R6 next after 5", 23, 300, '1);
    expect_instr("R6 wrap to 0", 0, 101, '1);
  endtask

  // R3, R8: ready drop mid-instruction does not cut it short
  task automatic t_mid_drop();
    do_reset();
    load(2, 40, '1);
    load(7, 70, '1);
    warp_ready_i[2] = 1'b1; warp_ready_i[7] = 1'b1;
    @(negedge clk);
    check_beat("R3 warp2 beat0", 1'b1, 2, 0, 8'hFF, 40);
    warp_ready_i[2] = 1'b0;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      check_beat("R3 no mid-instruction switch", 1'b1, 2, b, 8'hFF, 40);
    end
    expect_instr("R8 switch at boundary", 7, 70, '1);
    expect_instr("R8 lone warp repeats", 7, 71, '1);
    warp_ready_i[2] = 1'b1;
    expect_instr("R6 return to warp2", 2, 41, '1);
  endtask

  // R7, R5: zero-mask warp skipped, bubble, PC frozen while idle
  task automatic t_bubble();
    do_reset();
    load(4, 5, 32'h0);
    load(9, 9, 32'h0000_0001);
    warp_ready_i[4] = 1'b1; warp_ready_i[9] = 1'b1;
    @(negedge clk);
    check_beat("R7 zero-mask warp skipped", 1'b1, 9, 0, 8'h01, 9);
    warp_ready_i[9] = 1'b0;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      check_beat("R4 masked-off beats", 1'b1, 9, b, 8'h00, 9);
    end
    repeat (4) begin
      @(negedge clk);
      check_beat("R7 bubble", 1'b0, 0, 0, 8'h00, 0);
    end
    warp_ready_i[9] = 1'b1;
    @(negedge clk);
    check_beat("R5 pc stepped once over bubble", 1'b1, 9, 0, 8'h01, 10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: bench hung, expected completion within 20000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_single_warp();
    t_round_robin();
    t_mid_drop();
    t_bubble();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule